// File: doc/BRIEF.md
# Program Memory Table Pointer Unit

This block lets data-side instructions move single bytes between the data path and program memory. It keeps a 21-bit byte pointer into program memory and an 8-bit holding latch. A read operation fetches the byte at the chosen address into the latch. A write operation offers the latch byte, with its address, to a program-memory write buffer. The timing of flash erase and programming is left to that buffer.

Each operation carries a 2-bit pointer mode. The mode sets the address used for the access and the value the pointer holds once the operation ends. Every operation takes exactly two cycles, and the unit reports busy for those two cycles. Requests that arrive while it is busy are dropped. The data side can load the pointer and the latch directly while the unit is idle. No operation changes any condition flag, so the block has no flag outputs.

The memory port is synchronous. A strobe asserted in one cycle makes the memory return read data in the next cycle.

Top module: `tblptr_unit`

## Requirements
- R1: While reset is asserted and on its release, the pointer and the latch are zero, busy is low, and both memory strobes are low.
- R2: A pointer load or latch load takes effect on the next clock edge, but only when the unit is idle and no request is presented in the same cycle. In any other cycle the load has no effect.
- R3: A request sampled while idle raises busy from the next cycle for exactly two cycles. A request presented while busy is ignored and is not queued.
- R4: In the first busy cycle exactly one strobe is high, the read strobe for a read (write flag 0) or the write strobe for a write (write flag 1). Neither strobe is high in any other cycle.
- R5: After a read, from the cycle busy falls, the latch holds the byte the memory returned for the accessed address. The memory returns that byte one cycle after the strobe.
- R6: During a write strobe the write-data output equals the latch. A write leaves the latch unchanged.
- R7: Mode 00 accesses the pointer address and leaves the pointer unchanged.
- R8: Mode 01 accesses the pointer address, then the pointer becomes that address plus one.
- R9: Mode 10 accesses the pointer address, then the pointer becomes that address minus one.
- R10: Mode 11 accesses the pointer address plus one, and the pointer becomes that address.
- R11: Pointer arithmetic wraps modulo 2^21: 1FFFFF plus one gives 0, and 0 minus one gives 1FFFFF.
- R12: The pointer output stays stable while busy. It takes its new value on the edge at which busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a table operation |
| req_write | input | 1 | 1 for write, 0 for read |
| req_mode | input | 2 | Pointer mode: 00 hold, 01 post-increment, 10 post-decrement, 11 pre-increment |
| ptr_ld | input | 1 | Load the pointer from ptr_ld_val |
| ptr_ld_val | input | 21 | Pointer load value |
| lat_ld | input | 1 | Load the latch from lat_ld_val |
| lat_ld_val | input | 8 | Latch load value |
| ptr_q | output | 21 | Current pointer |
| latch_q | output | 8 | Current latch |
| busy | output | 1 | Operation in progress |
| mem_addr | output | 21 | Program memory byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe to the write buffer |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |

## Verification
Take a request sampled at edge N. Busy, the strobe and the access address appear after edge N. The memory answers at edge N+1. Busy falls, and the new pointer and the read byte appear in the latch, after edge N+2. A load sampled while idle shows after the very next edge. The bench reference model applies these same edge counts with its own counters. It compares every output at the falling edge of every cycle, so each result is checked exactly in the cycle it becomes due, and also in the cycles before and after.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD     = 2'b00,
    MODE_POST_INC = 2'b01,
    MODE_POST_DEC = 2'b10,
    MODE_PRE_INC  = 2'b11
  } tp_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_ACCESS = 2'b01,
    PH_SETTLE = 2'b10
  } tp_phase_e;

endpackage

// File: rtl/tp_sequencer.sv
module tp_sequencer
  import tp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     req_write,
  input  tp_mode_e req_mode,
  output logic     accept,
  output logic     load_ok,
  output logic     access_fire,
  output logic     commit_fire,
  output logic     busy,
  output logic     op_write,
  output tp_mode_e op_mode
);

  tp_phase_e phase_q, phase_d;

  assign accept      = req_valid && (phase_q == PH_IDLE);
  assign load_ok     = !req_valid && (phase_q == PH_IDLE);
  assign access_fire = (phase_q == PH_ACCESS);
  assign commit_fire = (phase_q == PH_SETTLE);
  assign busy        = (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (req_valid) phase_d = PH_ACCESS;
      PH_ACCESS: phase_d = PH_SETTLE;
      PH_SETTLE: phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      op_write <= 1'b0;
      op_mode  <= MODE_HOLD;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        op_write <= req_write;
        op_mode  <= req_mode;
      end
    end
  end

endmodule

// File: rtl/tp_pointer.sv
module tp_pointer
  import tp_pkg::*;
#(
  parameter int PTR_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             load_ok,
  input  logic             commit_fire,
  input  tp_mode_e         req_mode,
  input  tp_mode_e         op_mode,
  input  logic             ptr_ld,
  input  logic [PTR_W-1:0] ptr_ld_val,
  output logic [PTR_W-1:0] ptr_q,
  output logic [PTR_W-1:0] addr_q
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  // Address used by the access for a given mode.
  function automatic logic [PTR_W-1:0] access_addr(input logic [PTR_W-1:0] p,
                                                   input tp_mode_e m);
    return (m == MODE_PRE_INC) ? p + ONE : p;
  endfunction

  // Pointer value after the operation, derived from the accessed address.
  function automatic logic [PTR_W-1:0] final_ptr(input logic [PTR_W-1:0] a,
                                                 input tp_mode_e m);
    logic [PTR_W-1:0] r;
    unique case (m)
      MODE_POST_INC: r = a + ONE;
      MODE_POST_DEC: r = a - ONE;
      default:       r = a;
    endcase
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      addr_q <= '0;
    end else begin
      if (accept) addr_q <= access_addr(ptr_q, req_mode);
      if (commit_fire)          ptr_q <= final_ptr(addr_q, op_mode);
      else if (load_ok && ptr_ld) ptr_q <= ptr_ld_val;
    end
  end

endmodule

// File: rtl/tp_latch.sv
module tp_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ok,
  input  logic              commit_fire,
  input  logic              op_write,
  input  logic              lat_ld,
  input  logic [DATA_W-1:0] lat_ld_val,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] latch_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (commit_fire && !op_write) begin
      latch_q <= mem_rdata;
    end else if (load_ok && lat_ld) begin
      latch_q <= lat_ld_val;
    end
  end

endmodule

// File: rtl/tblptr_unit.sv
module tblptr_unit
  import tp_pkg::*;
#(
  parameter int PTR_W  = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_mode,
  input  logic              ptr_ld,
  input  logic [PTR_W-1:0]  ptr_ld_val,
  input  logic              lat_ld,
  input  logic [DATA_W-1:0] lat_ld_val,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [DATA_W-1:0] latch_q,
  output logic              busy,
  output logic [PTR_W-1:0]  mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic     accept, load_ok, access_fire, commit_fire, op_write;
  tp_mode_e op_mode_e, req_mode_e;
  logic [1:0] op_mode;

  assign req_mode_e = tp_mode_e'(req_mode);
  assign op_mode    = op_mode_e;

  tp_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_mode    (req_mode_e),
    .accept      (accept),
    .load_ok     (load_ok),
    .access_fire (access_fire),
    .commit_fire (commit_fire),
    .busy        (busy),
    .op_write    (op_write),
    .op_mode     (op_mode_e)
  );

  tp_pointer #(.PTR_W(PTR_W)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .load_ok     (load_ok),
    .commit_fire (commit_fire),
    .req_mode    (req_mode_e),
    .op_mode     (op_mode_e),
    .ptr_ld      (ptr_ld),
    .ptr_ld_val  (ptr_ld_val),
    .ptr_q       (ptr_q),
    .addr_q      (mem_addr)
  );

  tp_latch #(.DATA_W(DATA_W)) u_lat (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_ok     (load_ok),
    .commit_fire (commit_fire),
    .op_write    (op_write),
    .lat_ld      (lat_ld),
    .lat_ld_val  (lat_ld_val),
    .mem_rdata   (mem_rdata),
    .latch_q     (latch_q)
  );

  assign mem_rd    = access_fire && !op_write;
  assign mem_wr    = access_fire && op_write;
  assign mem_wdata = latch_q;

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int PTR_W  = 21,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [PTR_W-1:0]  mem_addr,
  input logic [PTR_W-1:0]  ptr_q,
  input logic [DATA_W-1:0] latch_q,
  input logic              commit_fire,
  input logic [1:0]        op_mode
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  a_r3_busy_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);
  a_r3_busy_not_single: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));
  a_r4_strobe_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (busy && !$past(busy)));
  a_r6_write_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> $stable(latch_q));
  a_r12_ptr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |=> $stable(ptr_q));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && op_mode == 2'b00) |=> ptr_q == $past(mem_addr));
  a_r8_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && op_mode == 2'b01) |=> ptr_q == $past(mem_addr) + ONE);
  a_r9_post_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && op_mode == 2'b10) |=> ptr_q == $past(mem_addr) - ONE);
  a_r10_pre_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && op_mode == 2'b11) |=> ptr_q == $past(mem_addr));

endmodule

bind tblptr_unit tp_checker #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .mem_addr    (mem_addr),
  .ptr_q       (ptr_q),
  .latch_q     (latch_q),
  .commit_fire (commit_fire),
  .op_mode     (op_mode)
);

// File: tb/tblptr_unit_bench.sv
module tblptr_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic ptr_ld = 1'b0, lat_ld = 1'b0;
  logic [AW-1:0] ptr_ld_val = '0;
  logic [7:0] lat_ld_val = '0;
  logic [AW-1:0] ptr_q, mem_addr;
  logic [7:0] latch_q, mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic busy, mem_rd, mem_wr;

  int n_checks = 0, n_fail = 0;
  bit checking = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tblptr_unit u_tblptr_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_mode(req_mode), .ptr_ld(ptr_ld), .ptr_ld_val(ptr_ld_val),
    .lat_ld(lat_ld), .lat_ld_val(lat_ld_val), .ptr_q(ptr_q), .latch_q(latch_q),
    .busy(busy), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Program memory model: computed contents plus a write buffer record.
  logic [7:0] wmem [int];
  function automatic logic [7:0] base_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    if (wmem.exists(int'(a))) return wmem[int'(a)];
    return base_byte(a);
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem_byte(mem_addr);
    if (mem_wr) wmem[int'(mem_addr)] = mem_wdata;
  end

  // Reference model
  int m_left = 0;
  logic [AW-1:0] m_ptr = '0, m_addr = '0;
  logic [7:0] m_lat = '0;
  bit m_wr = 0, m_wrap = 0;
  int m_mode = 0;
  string ptr_tag = "R1", lat_tag = "R1";

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R7";
      1: return "R8";
      2: return "R9";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_ptr = '0; m_lat = '0; ptr_tag = "R1"; lat_tag = "R1";
    end else if (m_left == 0) begin
      if (req_valid) begin
        m_left = 2; m_wr = req_write; m_mode = int'(req_mode);
        m_addr = (m_mode == 3) ? m_ptr + 1 : m_ptr;
        m_wrap = (m_mode == 3 && m_ptr == {AW{1'b1}});
        ptr_tag = "R12";
      end else begin
        if (ptr_ld) m_ptr = ptr_ld_val;
        if (lat_ld) m_lat = lat_ld_val;
        ptr_tag = "R2"; lat_tag = "R2";
      end
    end else begin
      m_left = m_left - 1;
      if (m_left == 0) begin
        if (!m_wr) begin m_lat = mem_byte(m_addr); lat_tag = "R5"; end
        else lat_tag = "R6";
        case (m_mode)
          1: begin m_ptr = m_addr + 1; if (m_addr == {AW{1'b1}}) m_wrap = 1; end
          2: begin m_ptr = m_addr - 1; if (m_addr == '0) m_wrap = 1; end
          default: m_ptr = m_addr;
        endcase
        ptr_tag = m_wrap ? "R11" : mode_tag(m_mode);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      chk("R3", 32'(busy), 32'(m_left != 0), "busy");
      chk("R4", 32'(mem_rd), 32'(m_left == 2 && !m_wr), "mem_rd");
      chk("R4", 32'(mem_wr), 32'(m_left == 2 && m_wr), "mem_wr");
      chk(ptr_tag, 32'(ptr_q), 32'(m_ptr), "ptr_q");
      chk(lat_tag, 32'(latch_q), 32'(m_lat), "latch_q");
      if (m_left == 2) chk(mode_tag(m_mode), 32'(mem_addr), 32'(m_addr), "mem_addr");
      if (mem_wr) chk("R6", 32'(mem_wdata), 32'(m_lat), "mem_wdata");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic quiet();
    req_valid = 0; ptr_ld = 0; lat_ld = 0;
  endtask
  task automatic load_ptr(input logic [AW-1:0] v);
    ptr_ld = 1; ptr_ld_val = v; cyc(1); quiet();
  endtask
  task automatic load_lat(input logic [7:0] v);
    lat_ld = 1; lat_ld_val = v; cyc(1); quiet();
  endtask
  task automatic op(input bit wr, input logic [1:0] md);
    req_valid = 1; req_write = wr; req_mode = md; cyc(1); quiet(); cyc(3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    // R1: reset values while reset is held
    chk("R1", 32'(ptr_q), 0, "ptr reset");
    chk("R1", 32'(latch_q), 0, "latch reset");
    chk("R1", 32'({busy, mem_rd, mem_wr}), 0, "busy/strobes reset");
    rst_n = 1; checking = 1;
    cyc(1);
    load_ptr(21'h001234); cyc(1);
    op(0, 2'b00); op(0, 2'b01); op(0, 2'b10); op(0, 2'b11);
    // R11 wrap cases
    load_ptr(21'h1FFFFF); op(0, 2'b01);
    op(0, 2'b10);
    load_ptr(21'h1FFFFF); op(0, 2'b11);
    // R6 write then read back
    load_ptr(21'h000400); load_lat(8'hC3); op(1, 2'b01);
    load_lat(8'h00); load_ptr(21'h000400); op(0, 2'b00);
    // R2 loads ignored during an op and alongside a request
    req_valid = 1; req_mode = 2'b01; req_write = 0; ptr_ld = 1; ptr_ld_val = 21'h0ABCDE;
    lat_ld = 1; lat_ld_val = 8'h77; cyc(1);
    req_valid = 0; cyc(2); quiet(); cyc(2);
    // R3 request held high: back-to-back ops, none queued
    req_valid = 1; req_mode = 2'b10; cyc(7); quiet(); cyc(3);
    // Random traffic
    for (int i = 0; i < 2000; i++) begin
      req_valid = ($urandom_range(0, 3) == 0);
      req_write = $urandom_range(0, 1);
      req_mode = 2'($urandom_range(0, 3));
      ptr_ld = ($urandom_range(0, 7) == 0);
      ptr_ld_val = ($urandom_range(0, 3) == 0) ? 21'h1FFFFE + 21'($urandom_range(0, 3))
                                               : 21'($urandom_range(0, 255));
      lat_ld = ($urandom_range(0, 5) == 0);
      lat_ld_val = 8'($urandom);
      cyc(1);
    end
    quiet(); cyc(4);
    checking = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule